// File: doc/BRIEF.md
# SerDes Control Register Bridge

This block turns a plain read or write request into the access sequence that a SerDes control-register space needs. That space cannot be reached directly. It holds a small command engine, and software talks to the engine through three mailbox registers: command/status, target address, and data. The mailbox registers are reached through a paged memory window. Before each window access, the block writes a page selector derived from the requester's device number and the mailbox register's internal address. Only then does it touch the word at the matching in-window offset.

Each request names a port. Each port has its own device number and window base address, supplied on configuration inputs. Only one request runs at a time. While a request runs, further requests are ignored.

Before every command, the bridge polls the busy flag. A read also polls after the command, and only then fetches the data register. Between busy reads the bridge waits a parameterised gap. A poll-count limit ends a stuck request with a timeout flag instead of hanging. Downstream, the bridge is a single-beat bus master that holds each beat until it is acknowledged.

Top module: `serdes_cr_bridge`

## Requirements
- R1: Out of reset, and whenever no request is in progress, `busy_o`, `bus_req_o` and `rsp_valid_o` are low.
- R2: Every mailbox access is two beats. The first beat is a bus write of page = (dev[4:0] << 7) | ((reg >> 9) & 0x7F) to base + 0x800. The second beat accesses base + ((reg & 0x1FF) << 2). The mailbox registers are command/status at internal address 0x80A0, address at 0x80A1 and data at 0x80A2. For these the page is (dev << 7) | 0x40, and the offsets are 0x280, 0x284 and 0x288.
- R3: A read performs, in order: busy poll until clear, write the target address, write command = 1, busy poll until clear, then read the data register.
- R4: A write performs, in order: busy poll until clear, write the target address, write the data, then write command = 3. It ends without polling afterwards.
- R5: In the command/status word, bit 0 is busy when read and start when written, and bit 1 written as 1 means write and as 0 means read. Bits above bit 0 of a status read are ignored.
- R6: After a status read that shows busy, the next status read completes no sooner than POLL_GAP+1 cycles later.
- R7: If MAX_POLLS status reads in one poll phase all show busy, the request ends with `rsp_timeout_o` = 1 and no further bus beats.
- R8: The device number and window base used for a request are those of the port given in `req_port_i` when the request is accepted.
- R9: Each accepted request produces exactly one single-cycle `rsp_valid_o` pulse. For a read that does not time out, `rsp_rdata_o` equals the low DATA_W bits of the data-register read. Otherwise `rsp_rdata_o` is 0.
- R10: A request is accepted only while `busy_o` is low. A `req_i` pulse while busy starts nothing and causes no response.
- R11: A bus beat keeps `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` unchanged until the cycle in which `bus_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_dev_i | input | NUM_PORTS*DEV_W | Device number per port |
| cfg_base_i | input | NUM_PORTS*BUS_AW | Window base address per port |
| req_i | input | 1 | Request strobe, sampled while idle |
| req_port_i | input | PORT_W | Requesting port index |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | SerDes internal register address |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Request in progress |
| rsp_valid_o | output | 1 | Single-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_timeout_o | output | 1 | Busy-poll limit reached |
| bus_req_o | output | 1 | Bus beat request |
| bus_we_o | output | 1 | Bus beat direction |
| bus_addr_o | output | BUS_AW | Bus byte address |
| bus_wdata_o | output | BUS_DW | Bus write data |
| bus_ack_i | input | 1 | Beat acknowledge |
| bus_rdata_i | input | BUS_DW | Bus read data, valid with ack |

## Verification
The bench models the window and the command engine. It sweeps both ports, both directions, zero to two busy reads before and after the command, and zero or one wait cycle on acknowledge, and it compares the full beat trace with one built arithmetically. Several mistakes show up as a trace mismatch: a skipped page write, a wrong page or offset, a command value with the wrong direction bit, or a write that polls after its command.

Status words carry garbage above bit 0, so a design that tests the whole word would hang polling. Those runs end with a timeout flag or the watchdog. Runs with MAX_POLLS and MAX_POLLS-1 busy reads check the poll limit: an off-by-one either times out early or performs one extra read. Timing is checked from the spacing between status reads, which catches a missing gap. A strobe sent in the middle of a request catches a bridge that restarts or answers twice.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int CR_AW = 16;
  localparam logic [CR_AW-1:0] MB_CMD  = 16'h80A0;
  localparam logic [CR_AW-1:0] MB_ADR  = 16'h80A1;
  localparam logic [CR_AW-1:0] MB_DAT  = 16'h80A2;
  localparam logic [11:0]      SEL_OFS = 12'h800;
  localparam logic [1:0]       CMD_START = 2'b01;
  localparam logic [1:0]       CMD_WRITE = 2'b10;

  typedef enum logic [2:0] {
    OP_POLL, OP_WR_ADDR, OP_WR_DATA, OP_WR_CMD, OP_RD_DATA, OP_DONE
  } mb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PG_GO, ST_PG_WT, ST_AC_GO, ST_AC_WT, ST_GAP, ST_RESP
  } seq_st_e;

  // step table: read polls twice, write polls once
  function automatic mb_op_e op_at(logic we, logic [2:0] step);
    mb_op_e op;
    op = OP_DONE;
    if (we) begin
      case (step)
        3'd0: op = OP_POLL;
        3'd1: op = OP_WR_ADDR;
        3'd2: op = OP_WR_DATA;
        3'd3: op = OP_WR_CMD;
        default: op = OP_DONE;
      endcase
    end else begin
      case (step)
        3'd0: op = OP_POLL;
        3'd1: op = OP_WR_ADDR;
        3'd2: op = OP_WR_CMD;
        3'd3: op = OP_POLL;
        3'd4: op = OP_RD_DATA;
        default: op = OP_DONE;
      endcase
    end
    return op;
  endfunction

  function automatic logic [CR_AW-1:0] mb_reg(mb_op_e op);
    logic [CR_AW-1:0] r;
    case (op)
      OP_WR_ADDR:             r = MB_ADR;
      OP_WR_DATA, OP_RD_DATA: r = MB_DAT;
      default:                r = MB_CMD;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sdb_win_map.sv
module sdb_win_map
  import sdb_pkg::*;
#(
  parameter int BUS_AW = 32,
  parameter int DEV_W  = 5,
  localparam int PG_W  = DEV_W + 7
) (
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [BUS_AW-1:0] base_i,
  input  logic [CR_AW-1:0]  reg_i,
  output logic [PG_W-1:0]   page_o,
  output logic [BUS_AW-1:0] sel_addr_o,
  output logic [BUS_AW-1:0] acc_addr_o
);
  logic [10:0] ofs;

  assign page_o     = {dev_i, reg_i[15:9]};
  assign ofs        = {reg_i[8:0], 2'b00};
  assign sel_addr_o = base_i + BUS_AW'(SEL_OFS);
  assign acc_addr_o = base_i + BUS_AW'(ofs);
endmodule

// File: rtl/sdb_poll_timer.sv
module sdb_poll_timer #(
  parameter int GAP_CYC   = 500,
  parameter int MAX_POLLS = 1000,
  localparam int GAP_W    = $clog2(GAP_CYC + 1),
  localparam int CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic busy_seen_i,
  input  logic gap_run_i,
  output logic gap_done_o,
  output logic limit_o
);
  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] polls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      polls_q <= '0;
    end else begin
      gap_q <= gap_run_i ? gap_q + GAP_W'(1) : '0;
      if (clear_i)          polls_q <= '0;
      else if (busy_seen_i) polls_q <= polls_q + CNT_W'(1);
    end
  end

  assign gap_done_o = gap_run_i && (gap_q == GAP_W'(GAP_CYC - 1));
  // true on the busy read that would be the MAX_POLLS-th in a row
  assign limit_o    = (polls_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/sdb_bus_port.sv
module sdb_bus_port #(
  parameter int BUS_AW = 32,
  parameter int BUS_DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              we_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] wdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [BUS_AW-1:0] bus_addr_o,
  output logic [BUS_DW-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else if (launch_i) begin
      bus_req_o   <= 1'b1;
      bus_we_o    <= we_i;
      bus_addr_o  <= addr_i;
      bus_wdata_o <= wdata_i;
    end else if (bus_req_o && bus_ack_i) begin
      bus_req_o   <= 1'b0;
    end
  end

  assign done_o = bus_req_o && bus_ack_i;
endmodule

// File: rtl/serdes_cr_bridge.sv
module serdes_cr_bridge
  import sdb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int BUS_AW    = 32,
  parameter int BUS_DW    = 32,
  parameter int DATA_W    = 16,
  parameter int DEV_W     = 5,
  parameter int POLL_GAP  = 500,
  parameter int MAX_POLLS = 1000,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PG_W     = DEV_W + 7
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS*DEV_W-1:0]  cfg_dev_i,
  input  logic [NUM_PORTS*BUS_AW-1:0] cfg_base_i,
  input  logic                        req_i,
  input  logic [PORT_W-1:0]           req_port_i,
  input  logic                        req_we_i,
  input  logic [CR_AW-1:0]            req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  output logic                        busy_o,
  output logic                        rsp_valid_o,
  output logic [DATA_W-1:0]           rsp_rdata_o,
  output logic                        rsp_timeout_o,
  output logic                        bus_req_o,
  output logic                        bus_we_o,
  output logic [BUS_AW-1:0]           bus_addr_o,
  output logic [BUS_DW-1:0]           bus_wdata_o,
  input  logic                        bus_ack_i,
  input  logic [BUS_DW-1:0]           bus_rdata_i
);
  logic [DEV_W-1:0]  dev_arr  [NUM_PORTS];
  logic [BUS_AW-1:0] base_arr [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cfg
    assign dev_arr[p]  = cfg_dev_i[p*DEV_W +: DEV_W];
    assign base_arr[p] = cfg_base_i[p*BUS_AW +: BUS_AW];
  end

  seq_st_e           st_q;
  logic [2:0]        step_q;
  logic              we_q;
  logic [CR_AW-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DEV_W-1:0]  dev_q;
  logic [BUS_AW-1:0] base_q;
  logic [DATA_W-1:0] rdata_q;
  logic              tmo_q;

  mb_op_e            cur_op, nxt_op;
  logic [2:0]        step_inc;
  logic [PG_W-1:0]   page;
  logic [BUS_AW-1:0] sel_addr, acc_addr;
  logic [BUS_DW-1:0] mb_val;
  logic              launch, l_we;
  logic [BUS_AW-1:0] l_addr;
  logic [BUS_DW-1:0] l_wdata;
  logic              beat_done;
  logic              acc_done, busy_seen, advance;
  logic              gap_done, poll_limit;

  assign step_inc = step_q + 3'd1;
  assign cur_op   = op_at(we_q, step_q);
  assign nxt_op   = op_at(we_q, step_inc);

  sdb_win_map #(.BUS_AW(BUS_AW), .DEV_W(DEV_W)) u_map (
    .dev_i      (dev_q),
    .base_i     (base_q),
    .reg_i      (mb_reg(cur_op)),
    .page_o     (page),
    .sel_addr_o (sel_addr),
    .acc_addr_o (acc_addr)
  );

  always_comb begin
    case (cur_op)
      OP_WR_ADDR: mb_val = BUS_DW'(addr_q);
      OP_WR_DATA: mb_val = BUS_DW'(wdata_q);
      OP_WR_CMD:  mb_val = BUS_DW'(we_q ? (CMD_WRITE | CMD_START) : CMD_START);
      default:    mb_val = '0;
    endcase
  end

  always_comb begin
    launch  = 1'b0;
    l_we    = 1'b1;
    l_addr  = sel_addr;
    l_wdata = BUS_DW'(page);
    if (st_q == ST_PG_GO) begin
      launch = 1'b1;
    end else if (st_q == ST_AC_GO) begin
      launch  = 1'b1;
      l_we    = (cur_op != OP_POLL) && (cur_op != OP_RD_DATA);
      l_addr  = acc_addr;
      l_wdata = mb_val;
    end
  end

  sdb_bus_port #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .we_i        (l_we),
    .addr_i      (l_addr),
    .wdata_i     (l_wdata),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .done_o      (beat_done)
  );

  assign acc_done  = (st_q == ST_AC_WT) && beat_done;
  assign busy_seen = acc_done && (cur_op == OP_POLL) && bus_rdata_i[0];
  assign advance   = acc_done && !busy_seen;

  sdb_poll_timer #(.GAP_CYC(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     ((st_q == ST_IDLE) || advance),
    .busy_seen_i (busy_seen),
    .gap_run_i   (st_q == ST_GAP),
    .gap_done_o  (gap_done),
    .limit_o     (poll_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      dev_q   <= '0;
      base_q  <= '0;
      rdata_q <= '0;
      tmo_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          we_q    <= req_we_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          dev_q   <= dev_arr[req_port_i];
          base_q  <= base_arr[req_port_i];
          step_q  <= '0;
          rdata_q <= '0;
          tmo_q   <= 1'b0;
          st_q    <= ST_PG_GO;
        end
        ST_PG_GO: st_q <= ST_PG_WT;
        ST_PG_WT: if (beat_done) st_q <= ST_AC_GO;
        ST_AC_GO: st_q <= ST_AC_WT;
        ST_AC_WT: if (busy_seen) begin
          if (poll_limit) begin
            tmo_q <= 1'b1;
            st_q  <= ST_RESP;
          end else begin
            st_q  <= ST_GAP;
          end
        end else if (advance) begin
          if (cur_op == OP_RD_DATA) rdata_q <= bus_rdata_i[DATA_W-1:0];
          step_q <= step_inc;
          st_q   <= (nxt_op == OP_DONE) ? ST_RESP : ST_PG_GO;
        end
        ST_GAP:  if (gap_done) st_q <= ST_PG_GO;
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign rsp_valid_o   = (st_q == ST_RESP);
  assign rsp_rdata_o   = rdata_q;
  assign rsp_timeout_o = tmo_q;
endmodule

// File: rtl/sdb_bridge_chk.sv
module sdb_bridge_chk #(
  parameter int BUS_AW = 32,
  parameter int BUS_DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              rsp_valid_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [BUS_AW-1:0] bus_addr_o,
  input logic [BUS_DW-1:0] bus_wdata_o,
  input logic              bus_ack_i,
  input logic [BUS_AW-1:0] sel_base_i
);
  logic pg_next_q;
  logic beat;

  assign beat = bus_req_o && bus_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pg_next_q <= 1'b1;
    else if (!busy_o) pg_next_q <= 1'b1;
    else if (beat)    pg_next_q <= !pg_next_q;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_req_o && !rsp_valid_o));

  assert_page_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && pg_next_q) |-> (bus_we_o && bus_addr_o == sel_base_i + BUS_AW'(12'h800)));

  assert_access_second_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat && !pg_next_q) |-> (bus_addr_o != sel_base_i + BUS_AW'(12'h800)));

  assert_quiet_at_resp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (!bus_req_o && pg_next_q));

  assert_rsp_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_accept_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i) |=> busy_o);

  assert_beat_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
                                   $stable(bus_addr_o) && $stable(bus_wdata_o)));
endmodule

bind serdes_cr_bridge sdb_bridge_chk #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .busy_o      (busy_o),
  .rsp_valid_o (rsp_valid_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .sel_base_i  (base_q)
);

// File: tb/serdes_cr_bridge_test.sv
module serdes_cr_bridge_test;
  localparam int NP = 2, GAP = 4, MAXP = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NP*5-1:0]  cfg_dev_i  = {5'd19, 5'd6};
  logic [NP*32-1:0] cfg_base_i = {32'h0004_2000, 32'h0001_0000};
  logic req_i = 1'b0, req_we_i = 1'b0;
  logic [0:0]  req_port_i = '0;
  logic [15:0] req_addr_i = '0, req_wdata_i = '0;
  logic busy_o, rsp_valid_o, rsp_timeout_o;
  logic [15:0] rsp_rdata_o;
  logic bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  serdes_cr_bridge #(.NUM_PORTS(NP), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_dev_i(cfg_dev_i), .cfg_base_i(cfg_base_i),
    .req_i(req_i), .req_port_i(req_port_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .busy_o(busy_o),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .rsp_timeout_o(rsp_timeout_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i));

  int checks = 0, errors = 0;
  logic        exp_w [128]; logic [31:0] exp_a [128]; logic [31:0] exp_d [128];
  logic        act_w [128]; logic [31:0] act_a [128]; logic [31:0] act_d [128];
  int exp_n, act_n;
  int busy_left, n1_cfg, lat_cfg, wait_c, cyc, last_poll, min_gap, rsp_cnt;
  bit prev_busy;
  logic [31:0] t_base;
  logic [15:0] mb_a;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // engine and window model
  always @(negedge clk_i) begin
    logic [31:0] off;
    cyc++;
    if (rsp_valid_o) rsp_cnt++;
    if (bus_ack_i) begin
      bus_ack_i = 1'b0;
      wait_c = 0;
    end else if (bus_req_o) begin
      if (wait_c >= lat_cfg) begin
        bus_ack_i = 1'b1;
        if (act_n < 128) begin
          act_w[act_n] = bus_we_o; act_a[act_n] = bus_addr_o; act_d[act_n] = bus_wdata_o;
          act_n++;
        end
        off = bus_addr_o - t_base;
        bus_rdata_i = 32'hFFFF_0000;
        if (!bus_we_o && off == 32'h280) begin
          bus_rdata_i = {31'h2B3C_4D5E, busy_left > 0};
          if (prev_busy && (cyc - last_poll) < min_gap) min_gap = cyc - last_poll;
          prev_busy = busy_left > 0;
          last_poll = cyc;
          if (busy_left > 0) busy_left--;
        end
        if (bus_we_o && off == 32'h280 && bus_wdata_o[0]) busy_left = n1_cfg;
        if (bus_we_o && off == 32'h284) mb_a = bus_wdata_o[15:0];
        if (!bus_we_o && off == 32'h288) bus_rdata_i = {16'hDEAD, mb_a ^ 16'hC3A5};
      end else wait_c++;
    end
  end

  task automatic add(logic w, logic [31:0] a, logic [31:0] d);
    exp_w[exp_n] = w; exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
  endtask

  task automatic add_polls(int n, logic [31:0] base, logic [31:0] pg, output bit tmo);
    int k;
    tmo = (n >= MAXP);
    k = tmo ? MAXP : n + 1;
    for (int i = 0; i < k; i++) begin
      add(1'b1, base + 32'h800, pg);
      add(1'b0, base + 32'h280, 32'h0);
    end
  endtask

  task automatic run(int p, bit we, logic [15:0] a, logic [15:0] d, int n0, int n1,
                     int lat, bit extra);
    logic [31:0] base, pg;
    logic [15:0] exp_rd, got_rd;
    bit exp_tmo, got_tmo, got, t;
    string tag;
    base = (p == 0) ? 32'h0001_0000 : 32'h0004_2000;
    pg   = (p == 0) ? ((32'd6 << 7) | 32'h40) : ((32'd19 << 7) | 32'h40);
    exp_n = 0; exp_rd = 16'h0; exp_tmo = 1'b0;
    add_polls(n0, base, pg, t);
    if (t) exp_tmo = 1'b1;
    else if (we) begin
      add(1'b1, base + 32'h800, pg); add(1'b1, base + 32'h284, {16'h0, a});
      add(1'b1, base + 32'h800, pg); add(1'b1, base + 32'h288, {16'h0, d});
      add(1'b1, base + 32'h800, pg); add(1'b1, base + 32'h280, 32'h3);
    end else begin
      add(1'b1, base + 32'h800, pg); add(1'b1, base + 32'h284, {16'h0, a});
      add(1'b1, base + 32'h800, pg); add(1'b1, base + 32'h280, 32'h1);
      add_polls(n1, base, pg, t);
      if (t) exp_tmo = 1'b1;
      else begin
        add(1'b1, base + 32'h800, pg); add(1'b0, base + 32'h288, 32'h0);
        exp_rd = a ^ 16'hC3A5;
      end
    end
    busy_left = n0; n1_cfg = n1; lat_cfg = lat; act_n = 0; rsp_cnt = 0;
    min_gap = 1000000; prev_busy = 1'b0; t_base = base;
    @(negedge clk_i);
    req_port_i = 1'(p); req_we_i = we; req_addr_i = a; req_wdata_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk_i);
      req_port_i = 1'(1 - p); req_we_i = !we; req_addr_i = ~a; req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    got = 1'b0; got_rd = '0; got_tmo = 1'b0;
    for (int k = 0; k < 3000 && !got; k++) begin
      @(negedge clk_i);
      if (rsp_valid_o) begin got = 1'b1; got_rd = rsp_rdata_o; got_tmo = rsp_timeout_o; end
    end
    check(got, "R9", "response seen before watchdog", {31'h0, got}, 32'h1);
    repeat (8) @(negedge clk_i);
    tag = we ? "R2 R4 R5 R8" : "R2 R3 R5 R8";
    if (lat > 0) tag = {tag, " R11"};
    begin
      bit ok;
      ok = (act_n == exp_n);
      for (int i = 0; i < exp_n && ok; i++)
        ok = (act_w[i] == exp_w[i]) && (act_a[i] == exp_a[i]) &&
             (!exp_w[i] || act_d[i] == exp_d[i]);
      check(ok, tag, "beat trace (count)", act_n, exp_n);
    end
    check(got_rd == exp_rd, "R9", "response data", {16'h0, got_rd}, {16'h0, exp_rd});
    check(got_tmo == exp_tmo, "R7", "timeout flag", {31'h0, got_tmo}, {31'h0, exp_tmo});
    check(rsp_cnt == 1 && !busy_o, extra ? "R10" : "R9", "single response then idle",
          rsp_cnt, 1);
    if (min_gap != 1000000)
      check(min_gap >= GAP + 1, "R6", "spacing of busy polls", min_gap, GAP + 1);
  endtask

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc = 0; mb_a = '0; busy_left = 0; n1_cfg = 0; lat_cfg = 0; wait_c = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !bus_req_o && !rsp_valid_o, "R1", "idle after reset",
          {busy_o, bus_req_o, rsp_valid_o}, 32'h0);
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < 2; w++)
        for (int n0 = 0; n0 < 3; n0++)
          for (int lat = 0; lat < 2; lat++)
            run(p, w[0], 16'(16'h1234 + 16'h0351 * (p * 12 + w * 6 + n0 * 2 + lat)),
                16'(16'hA55A ^ (n0 * 16'h0F0F)), n0, (n0 + lat) % 3, lat, 1'b0);
    run(0, 1'b0, 16'hFE01, 16'h0, MAXP, 0, 0, 1'b0);      // R7 poll limit before command
    run(1, 1'b0, 16'h0200, 16'h0, 1, MAXP, 1, 1'b0);      // R7 poll limit after command
    run(1, 1'b1, 16'h7FFF, 16'hBEEF, MAXP, 0, 0, 1'b0);   // R7 on write
    run(0, 1'b0, 16'h8123, 16'h0, MAXP - 1, MAXP - 1, 0, 1'b0); // R7 boundary: no timeout
    run(0, 1'b1, 16'h4444, 16'h1357, 0, MAXP, 0, 1'b0);   // R4 write does not re-poll
    run(1, 1'b0, 16'h0C0C, 16'h0, 2, 1, 0, 1'b1);         // R10 strobe while busy
    run(0, 1'b1, 16'h3003, 16'h9009, 1, 0, 1, 1'b1);      // R10 strobe while busy
    @(negedge clk_i);
    check(!busy_o && !bus_req_o, "R1", "idle at end", {busy_o, bus_req_o}, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule